// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block collects the data bytes of a serial memory page-write command and then runs a self-timed programming cycle that copies them into the storage array. A command decoder in front of it reports four kinds of event: the start of a write command together with the start address, each complete data byte, and the release of chip select. With the release it also says whether the release fell exactly on a byte boundary. A protection unit beside it says whether the target page may be written. The block also holds the write-enable latch, which the decoder sets or clears on the matching commands.

Bytes are placed in a 128-entry page buffer. The first byte goes to the in-page offset taken from the low address bits. The offset then advances and wraps inside the page, so a long burst overwrites the bytes it loaded earlier. A per-slot mask records which entries were loaded. Programming starts only on an aligned release with the latch set and protection granted. During programming, the loaded slots are written one per cycle to the array write port, and busy is held for a fixed, parameterised number of cycles. When the cycle ends, busy drops and the write-enable latch clears itself. While busy is high, all other events are ignored.

Top module: `page_write_buffer`

## Requirements
- R1: After reset busy_o is 0, wel_o is 0 and arr_we_o is 0.
- R2: A pulse on wel_set_i sets wel_o on the next cycle. A pulse on wel_clr_i clears it. When both arrive in the same cycle, the clear wins.
- R3: A write start that arrives while wel_o is 0 is ignored. The bytes and the release that follow cause no array write and no busy.
- R4: Byte k of a command (k counted from 0) lands at in-page offset (start_addr_i[6:0] + k) mod 128. Its array address is {start_addr_i[ADDR_W-1:7], that offset}.
- R5: When more than 128 bytes arrive, later bytes overwrite earlier ones at the same offset, and only the last value per offset is written.
- R6: A release with on_byte_i = 0 aborts the command. No array write occurs, busy stays 0, and wel_o keeps its value.
- R7: A release with prot_ok_i = 0 suppresses the commit entirely. No array write occurs, busy stays 0, and wel_o keeps its value.
- R8: An accepted release raises busy_o on the next cycle, and busy_o stays high for exactly PROG_CYCLES cycles.
- R9: A commit writes each loaded offset exactly once and writes no other offset. The loaded-slot record is cleared at each accepted write start. All array writes happen while busy_o is 1.
- R10: wel_o is 0 from the cycle in which busy_o falls.
- R11: While busy_o is 1, write starts, data bytes and releases are ignored. They cause no extra array write and do not lengthen busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wel_set_i | input | 1 | Set the write-enable latch (one-cycle pulse) |
| wel_clr_i | input | 1 | Clear the write-enable latch (one-cycle pulse) |
| wr_start_i | input | 1 | Write command accepted, address valid (one-cycle pulse) |
| start_addr_i | input | ADDR_W | Start address of the write command |
| byte_vld_i | input | 1 | A complete data byte is on byte_i |
| byte_i | input | 8 | Received data byte |
| cs_rise_i | input | 1 | Chip select released (one-cycle pulse) |
| on_byte_i | input | 1 | Release fell exactly after a full byte |
| prot_ok_i | input | 1 | Target page is writable, sampled with the release |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Programming cycle in progress |
| wel_o | output | 1 | Write-enable latch state |

## Verification
The assertions take several properties of the inputs for granted. Every event input is a single-cycle pulse. A release never coincides with a byte or a write start. PROG_CYCLES is at least 128, so the serial copy finishes before busy ends. The bench drives at most one event per clock: it changes inputs only at the falling edge and returns them to zero on the next falling edge. It holds the release qualifiers only for the release cycle and uses a PROG_CYCLES override of 150, which keeps the copy inside the busy window.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;
endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
    parameter int PAGE_BYTES = 128,
    parameter int OFF_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [OFF_W-1:0] init_off_i,
    input  logic             load_i,
    input  logic [7:0]       byte_i,
    input  logic [OFF_W-1:0] rd_idx_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_vld_o,
    output logic             any_o
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] mem;
        logic [PAGE_BYTES-1:0]      mask;
        logic [OFF_W-1:0]           off;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.mask = '0;
            st_d.off  = init_off_i;
        end else if (load_i) begin
            st_d.mem[st_q.off]  = byte_i;
            st_d.mask[st_q.off] = 1'b1;
            st_d.off            = st_q.off + OFF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.mem[rd_idx_i];
    assign rd_vld_o  = st_q.mask[rd_idx_i];
    assign any_o     = |st_q.mask;

    // R4: the offset wraps inside the page
    assert_offset_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i && st_q.off == '1) |=> st_q.off == '0);
    // R9: loaded-slot record cleared at an accepted start
    assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> st_q.mask == '0);
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int PROG_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = st_q.active && (st_q.cnt == LAST);
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (done_o) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.active;

    // R8: the count never passes the programmed length
    assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> st_q.cnt <= LAST);
    // R8: a new cycle only starts from idle
    assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !st_q.active);
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wel_set_i,
    input  logic                    wel_clr_i,
    input  logic                    wr_start_i,
    input  logic [ADDR_W-OFF_W-1:0] page_i,
    input  logic                    byte_vld_i,
    input  logic                    cs_rise_i,
    input  logic                    on_byte_i,
    input  logic                    prot_ok_i,
    input  logic                    any_loaded_i,
    input  logic                    slot_vld_i,
    input  logic                    tmr_done_i,
    output logic                    store_clear_o,
    output logic                    store_load_o,
    output logic                    tmr_start_o,
    output logic [OFF_W-1:0]        scan_idx_o,
    output logic                    arr_we_o,
    output logic [ADDR_W-OFF_W-1:0] arr_page_o,
    output logic                    wel_o
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    typedef struct packed {
        phase_e            phase;
        logic              wel;
        logic [PAGE_W-1:0] page;
        logic [OFF_W:0]    scan;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        store_clear_o = 1'b0;
        store_load_o  = 1'b0;
        tmr_start_o   = 1'b0;

        if (st_q.phase != PH_PROG) begin
            if (wel_clr_i)      st_d.wel = 1'b0;
            else if (wel_set_i) st_d.wel = 1'b1;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (wr_start_i && st_q.wel) begin
                    st_d.phase    = PH_LOAD;
                    st_d.page     = page_i;
                    store_clear_o = 1'b1;
                end
            end
            PH_LOAD: begin
                if (wr_start_i) begin
                    if (st_q.wel) begin
                        st_d.page     = page_i;
                        store_clear_o = 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end else if (byte_vld_i) begin
                    store_load_o = 1'b1;
                end else if (cs_rise_i) begin
                    if (on_byte_i && prot_ok_i && any_loaded_i && st_q.wel) begin
                        st_d.phase  = PH_PROG;
                        st_d.scan   = '0;
                        tmr_start_o = 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end
            end
            PH_PROG: begin
                if (!st_q.scan[OFF_W]) st_d.scan = st_q.scan + (OFF_W+1)'(1);
                if (tmr_done_i) begin
                    st_d.phase = PH_IDLE;
                    st_d.wel   = 1'b0;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_idx_o = st_q.scan[OFF_W-1:0];
    assign arr_page_o = st_q.page;
    assign arr_we_o   = (st_q.phase == PH_PROG) && !st_q.scan[OFF_W] && slot_vld_i;
    assign wel_o      = st_q.wel;

    // R2: clear has priority over set outside programming
    assert_wel_clr_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_clr_i && st_q.phase != PH_PROG) |=> !st_q.wel);
    // R3: a start without the latch leaves the block idle
    assert_ignore_no_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && wr_start_i && !st_q.wel) |=> st_q.phase == PH_IDLE);
    // R6: an unaligned release aborts
    assert_abort_unaligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_LOAD && cs_rise_i && !wr_start_i && !byte_vld_i && !on_byte_i)
        |=> st_q.phase == PH_IDLE);
    // R7: a protected release never programs
    assert_protect_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_LOAD && cs_rise_i && !prot_ok_i) |=> st_q.phase != PH_PROG);
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BYTES  = 128,
    parameter int PROG_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              wr_start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              cs_rise_i,
    input  logic              on_byte_i,
    input  logic              prot_ok_i,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [7:0]        arr_data_o,
    output logic              busy_o,
    output logic              wel_o
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              store_clear, store_load, tmr_start, tmr_done;
    logic              slot_vld, any_loaded;
    logic [OFF_W-1:0]  scan_idx;
    logic [PAGE_W-1:0] arr_page;

    pwb_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wel_set_i     (wel_set_i),
        .wel_clr_i     (wel_clr_i),
        .wr_start_i    (wr_start_i & ~busy_o),
        .page_i        (start_addr_i[ADDR_W-1:OFF_W]),
        .byte_vld_i    (byte_vld_i),
        .cs_rise_i     (cs_rise_i),
        .on_byte_i     (on_byte_i),
        .prot_ok_i     (prot_ok_i),
        .any_loaded_i  (any_loaded),
        .slot_vld_i    (slot_vld),
        .tmr_done_i    (tmr_done),
        .store_clear_o (store_clear),
        .store_load_o  (store_load),
        .tmr_start_o   (tmr_start),
        .scan_idx_o    (scan_idx),
        .arr_we_o      (arr_we_o),
        .arr_page_o    (arr_page),
        .wel_o         (wel_o)
    );

    pwb_page_store #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (store_clear),
        .init_off_i (start_addr_i[OFF_W-1:0]),
        .load_i     (store_load),
        .byte_i     (byte_i),
        .rd_idx_i   (scan_idx),
        .rd_data_o  (arr_data_o),
        .rd_vld_o   (slot_vld),
        .any_o      (any_loaded)
    );

    pwb_cycle_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .busy_o  (busy_o),
        .done_o  (tmr_done)
    );

    assign arr_addr_o = {arr_page, scan_idx};

    // R9: array writes only inside the programming window
    assert_we_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);
    // R10: latch is clear once busy falls
    assert_wel_autoclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !wel_o);
    // R8: busy only rises after a release
    assert_busy_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cs_rise_i));
endmodule

// File: tb/test_page_write_buffer.sv
module test_page_write_buffer;
    localparam int AW   = 16;
    localparam int PROG = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wel_set = 0, wel_clr = 0, wr_start = 0, byte_vld = 0, cs_rise = 0;
    logic on_byte = 0, prot_ok = 0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0] byte_d = '0;
    logic arr_we, busy, wel;
    logic [AW-1:0] arr_addr;
    logic [7:0] arr_data;

    always #4 clk = ~clk;

    page_write_buffer #(.ADDR_W(AW), .PAGE_BYTES(128), .PROG_CYCLES(PROG)) i_page_write_buffer (
        .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
        .wr_start_i(wr_start), .start_addr_i(start_addr), .byte_vld_i(byte_vld),
        .byte_i(byte_d), .cs_rise_i(cs_rise), .on_byte_i(on_byte), .prot_ok_i(prot_ok),
        .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_data_o(arr_data),
        .busy_o(busy), .wel_o(wel)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int wr_cnt, busy_cnt, we_outside;
    logic [7:0] got [int];
    logic [7:0] expd [128];
    bit expm [128];

    always @(negedge clk) begin
        if (arr_we) begin
            wr_cnt++;
            got[int'(arr_addr)] = arr_data;
            if (!busy) we_outside++;
        end
        if (busy) busy_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wel(input bit s, input bit c);
        @(negedge clk); wel_set = s; wel_clr = c;
        @(negedge clk); wel_set = 0; wel_clr = 0;
    endtask

    task automatic clear_obs();
        wr_cnt = 0; busy_cnt = 0; we_outside = 0; got.delete();
    endtask

    // drive one command; model fills expd/expm
    task automatic send_write(input int addr, input int n, input int seed,
                              input bit aligned, input bit prot);
        int off;
        foreach (expm[i]) expm[i] = 0;
        off = addr & 127;
        @(negedge clk); wr_start = 1; start_addr = AW'(addr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wr_start = 0; byte_vld = 1;
            byte_d = 8'((seed + i * 7) & 255);
            expd[off] = byte_d; expm[off] = 1; off = (off + 1) & 127;
        end
        @(negedge clk); wr_start = 0; byte_vld = 0;
        cs_rise = 1; on_byte = aligned; prot_ok = prot;
        @(negedge clk); cs_rise = 0; on_byte = 0; prot_ok = 0;
    endtask

    task automatic check_page(input int addr, input string req);
        int base, nexp, bad;
        base = addr & ~127; nexp = 0; bad = 0;
        for (int o = 0; o < 128; o++) begin
            if (expm[o]) begin
                nexp++;
                if (!got.exists(base + o) || got[base + o] != expd[o]) bad++;
            end
        end
        chk(bad == 0, req, bad, 0);
        chk(wr_cnt == nexp, req, wr_cnt, nexp);
    endtask

    task automatic t_reset();
        chk(busy == 0 && wel == 0 && arr_we == 0, "R1", {busy, wel, arr_we}, 0);
    endtask

    task automatic t_latch();
        pulse_wel(1, 0); chk(wel == 1, "R2", wel, 1);
        pulse_wel(1, 1); chk(wel == 0, "R2", wel, 0);
        pulse_wel(0, 1); chk(wel == 0, "R2", wel, 0);
    endtask

    task automatic t_no_latch();
        clear_obs();
        send_write('h0400, 3, 9, 1, 1);
        wait_cyc(PROG + 8);
        chk(busy_cnt == 0, "R3", busy_cnt, 0);
        chk(wr_cnt == 0, "R3", wr_cnt, 0);
    endtask

    task automatic t_partial_wrap();
        pulse_wel(1, 0); clear_obs();
        send_write('h1A7C, 8, 3, 1, 1);
        wait_cyc(PROG + 8);
        check_page('h1A7C, "R4");
        chk(busy_cnt == PROG, "R8", busy_cnt, PROG);
        chk(we_outside == 0, "R9", we_outside, 0);
        chk(wel == 0, "R10", wel, 0);
    endtask

    task automatic t_overflow();
        pulse_wel(1, 0); clear_obs();
        send_write('h0305, 130, 17, 1, 1);
        wait_cyc(PROG + 8);
        check_page('h0305, "R5");
        chk(got.exists('h0305) && got['h0305] == 8'((17 + 128 * 7) & 255), "R5",
            got.exists('h0305) ? int'(got['h0305]) : -1, (17 + 128 * 7) & 255);
    endtask

    task automatic t_mask_clear();
        pulse_wel(1, 0); clear_obs();
        send_write('h0340, 2, 77, 1, 1);
        wait_cyc(PROG + 8);
        check_page('h0340, "R9");
    endtask

    task automatic t_abort();
        pulse_wel(1, 0); clear_obs();
        send_write('h2000, 5, 40, 0, 1);
        wait_cyc(PROG + 8);
        chk(busy_cnt == 0 && wr_cnt == 0, "R6", busy_cnt + wr_cnt, 0);
        chk(wel == 1, "R6", wel, 1);
    endtask

    task automatic t_protect();
        clear_obs();
        send_write('h3000, 5, 50, 1, 0);
        wait_cyc(PROG + 8);
        chk(busy_cnt == 0 && wr_cnt == 0, "R7", busy_cnt + wr_cnt, 0);
        chk(wel == 1, "R7", wel, 1);
    endtask

    task automatic t_busy_ignore();
        clear_obs();
        send_write('h4010, 4, 90, 1, 1);
        wait_cyc(20);
        @(negedge clk); wr_start = 1; start_addr = 16'h5000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); wr_start = 0; byte_vld = 1; byte_d = 8'(i + 200);
        end
        @(negedge clk); byte_vld = 0; cs_rise = 1; on_byte = 1; prot_ok = 1;
        @(negedge clk); cs_rise = 0; on_byte = 0; prot_ok = 0;
        wait_cyc(PROG + 8);
        check_page('h4010, "R11");
        chk(busy_cnt == PROG, "R11", busy_cnt, PROG);
        chk(busy == 0, "R11", busy, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(2);
        t_reset();
        t_latch();
        t_no_latch();
        t_partial_wrap();
        t_overflow();
        t_mask_clear();
        t_abort();
        t_protect();
        t_busy_ignore();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule